// File: doc/BRIEF.md
# Byte Serial Shifter with Completion Flag

This block is a small peripheral that turns a byte written by a host into an eight-bit serial stream, or gathers eight serial bits into a byte for the host to read. It has its own divided serial clock. The host reaches it through four byte-wide registers: data, control, flags and interrupt enable.

A 3-bit mode field in the control register selects one of three behaviours: shift in, shift out, or idle. Any access to the data register starts a sequence from bit zero. After the eighth serial clock rising edge, the block raises a completion flag. The host can poll that flag, or route it to an interrupt line through an enable bit.

In shift-in mode the block keeps running after each byte. The host must therefore collect each byte before the next eight bits arrive, or that byte is overwritten. In shift-out mode the block stops after one byte and parks the serial clock high.

Top module: `ssr_top`

## Requirements
- R1: After reset, all registers read zero, the serial clock output is high, the serial data output is low and the interrupt output is low.
- R2: The register map is fixed. Address 0 is data, read and write. Address 1 is control, with the mode in bits 4:2 and all other bits reading zero. Address 2 is flags, with the completion flag in bit 2. Address 3 is interrupt enable, in bit 2.
- R3: Mode 3'b001 shifts in and mode 3'b101 shifts out. Every other code, including 3'b000, disables the shifter. While disabled, the serial clock stays high, the serial data output holds its value and the flag is never set. A write to the data register still loads the byte.
- R4: A write or read at address 0 restarts the sequence from bit zero. It clears the bit count, resets the divider, drives the serial clock high and, for a write, loads the byte. The completion then falls 16*DIV_HALF cycles after the most recent access.
- R5: While a sequence runs, the serial clock toggles once every DIV_HALF system clock cycles.
- R6: Shift-out sends the byte MSB first. The serial data output changes on the falling serial clock edge and is valid at the following rising edge. Bits vacated by the shift fill with zero.
- R7: Shift-in samples the serial input on each rising serial clock edge into the LSB. After eight bits, the first bit received sits in bit 7 of the data register.
- R8: The completion flag is set on the edge of the eighth rising serial clock edge, which is exactly 16*DIV_HALF cycles after the starting access. In shift-out mode the sequence then stops with the serial clock high.
- R9: Shift-in continues after each byte and sets the flag again after every further eight bits. A byte the host has not read is overwritten by the next one.
- R10: Any access to the data register clears the completion flag on the next edge.
- R11: The interrupt output is high exactly when the completion flag and the enable bit are both set.
- R12: Changing the mode to a disabled code in the middle of a sequence halts it. The serial clock returns high and no completion flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (side effects only) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed register, combinational |
| ser_clk_o | output | 1 | Serial clock, idle high |
| ser_out_o | output | 1 | Serial data output |
| ser_in_i | input | 1 | Serial data input |
| irq_o | output | 1 | Interrupt: completion flag AND enable |

## Verification
The bench places the flag check on the exact cycle, 16*DIV_HALF edges after an access. An off-by-one bit counter therefore shows up as a flag that is early or late by one serial period. A restart written in the middle of a byte must push the completion back. A design that keeps the old count would flag too early.

Two shift-in bytes are streamed back to back without a read in between. This exposes a shifter that stops after one byte, or one that drops the bit at the byte boundary.

Unused mode codes, and dropping the mode to zero in the middle of a sequence, are checked for a serial clock that never goes low and a flag that stays clear. A decoder that treats any nonzero code as enabled would toggle the clock in these cases.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  // Byte geometry
  localparam int SSR_DW    = 8;
  localparam int SSR_BITS  = 8;
  localparam int SSR_CNT_W = $clog2(SSR_BITS);

  // Register addresses
  localparam int SSR_A_DATA  = 0;
  localparam int SSR_A_CTRL  = 1;
  localparam int SSR_A_FLAGS = 2;
  localparam int SSR_A_IEN   = 3;

  // Field positions
  localparam int SSR_MODE_LSB = 2;
  localparam int SSR_MODE_W   = 3;
  localparam int SSR_FLAG_BIT = 2;

  typedef enum logic [SSR_MODE_W-1:0] {
    SSR_OFF     = 3'b000,
    SSR_IN_INT  = 3'b001,
    SSR_OUT_INT = 3'b101
  } ssr_mode_e;

  // Only the two internal-clock codes run the shifter
  function automatic logic mode_runs(input logic [SSR_MODE_W-1:0] m);
    return (m == SSR_IN_INT) || (m == SSR_OUT_INT);
  endfunction

  // Shift one place toward the MSB, new bit entering at the LSB
  function automatic logic [SSR_DW-1:0] shift_fill(input logic [SSR_DW-1:0] v,
                                                   input logic b);
    return {v[SSR_DW-2:0], b};
  endfunction

  // System cycles from an access to the completion edge
  function automatic int byte_cycles(input int half);
    return 2 * SSR_BITS * half;
  endfunction

endpackage

// File: rtl/ssr_regs.sv
module ssr_regs
  import ssr_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [SSR_DW-1:0]     wdata_i,
  input  logic [SSR_DW-1:0]     shreg_i,
  input  logic                  flag_i,
  output logic [SSR_DW-1:0]     rdata_o,
  output logic [SSR_MODE_W-1:0] mode_o,
  output logic                  irq_en_o,
  output logic                  data_acc_o,
  output logic                  data_wr_o,
  output logic [SSR_DW-1:0]     load_o
);

  logic sel_data, sel_ctrl, sel_flags, sel_ien;
  logic [SSR_MODE_W-1:0] mode_q;
  logic ien_q;

  assign sel_data  = (addr_i == ADDR_W'(SSR_A_DATA));
  assign sel_ctrl  = (addr_i == ADDR_W'(SSR_A_CTRL));
  assign sel_flags = (addr_i == ADDR_W'(SSR_A_FLAGS));
  assign sel_ien   = (addr_i == ADDR_W'(SSR_A_IEN));

  assign data_acc_o = sel_data & (wr_i | rd_i);
  assign data_wr_o  = sel_data & wr_i;
  assign load_o     = wdata_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mode_q <= SSR_OFF;
      ien_q  <= 1'b0;
    end else begin
      if (wr_i && sel_ctrl) mode_q <= wdata_i[SSR_MODE_LSB +: SSR_MODE_W];
      if (wr_i && sel_ien)  ien_q  <= wdata_i[SSR_FLAG_BIT];
    end
  end

  assign mode_o   = mode_q;
  assign irq_en_o = ien_q;

  always_comb begin
    rdata_o = '0;
    if (sel_data) rdata_o = shreg_i;
    if (sel_ctrl) rdata_o[SSR_MODE_LSB +: SSR_MODE_W] = mode_q;
    if (sel_flags) rdata_o[SSR_FLAG_BIT] = flag_i;
    if (sel_ien) rdata_o[SSR_FLAG_BIT] = ien_q;
  end

endmodule

// File: rtl/ssr_clkgen.sv
module ssr_clkgen #(
  parameter int DIV_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic en_i,
  input  logic restart_i,
  output logic tick_o,
  output logic fall_o,
  output logic rise_o,
  output logic sclk_o
);

  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] div_q;
  logic sclk_q;
  logic run;

  // A restart or a disabled mode parks the divider
  assign run    = active_i & en_i & ~restart_i;
  assign tick_o = run && (div_q == CW'(DIV_HALF - 1));
  assign fall_o = tick_o & sclk_q;
  assign rise_o = tick_o & ~sclk_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      div_q  <= '0;
      sclk_q <= 1'b1;
    end else if (!run) begin
      div_q  <= '0;
      sclk_q <= 1'b1;
    end else if (tick_o) begin
      div_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      div_q  <= div_q + CW'(1);
    end
  end

endmodule

// File: rtl/ssr_shifter.sv
module ssr_shifter
  import ssr_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [SSR_MODE_W-1:0] mode_i,
  input  logic                  data_acc_i,
  input  logic                  data_wr_i,
  input  logic [SSR_DW-1:0]     load_i,
  input  logic                  fall_i,
  input  logic                  rise_i,
  input  logic                  ser_in_i,
  output logic [SSR_DW-1:0]     shreg_o,
  output logic                  ser_out_o,
  output logic                  active_o,
  output logic                  flag_o,
  output logic                  byte_done_o
);

  logic [SSR_DW-1:0]    shreg_q;
  logic [SSR_CNT_W-1:0] cnt_q;
  logic sout_q, active_q, flag_q;
  logic en, is_in, is_out;

  assign en     = mode_runs(mode_i);
  assign is_in  = (mode_i == SSR_IN_INT);
  assign is_out = (mode_i == SSR_OUT_INT);

  // Eighth rising serial edge of the current byte
  assign byte_done_o = rise_i && (cnt_q == SSR_CNT_W'(SSR_BITS - 1));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      shreg_q  <= '0;
      cnt_q    <= '0;
      sout_q   <= 1'b0;
      active_q <= 1'b0;
      flag_q   <= 1'b0;
    end else if (data_acc_i) begin
      cnt_q    <= '0;
      flag_q   <= 1'b0;
      active_q <= en;
      if (data_wr_i) shreg_q <= load_i;
    end else if (!en) begin
      active_q <= 1'b0;
    end else begin
      if (fall_i && is_out) begin
        sout_q  <= shreg_q[SSR_DW-1];
        shreg_q <= shift_fill(shreg_q, 1'b0);
      end
      if (rise_i) begin
        cnt_q <= byte_done_o ? '0 : cnt_q + SSR_CNT_W'(1);
        if (is_in) shreg_q <= shift_fill(shreg_q, ser_in_i);
      end
      if (byte_done_o) begin
        flag_q <= 1'b1;
        if (is_out) active_q <= 1'b0;
      end
    end
  end

  assign shreg_o   = shreg_q;
  assign ser_out_o = sout_q;
  assign active_o  = active_q;
  assign flag_o    = flag_q;

endmodule

// File: rtl/ssr_top.sv
module ssr_top
  import ssr_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int DIV_HALF = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [SSR_DW-1:0] reg_wdata_i,
  output logic [SSR_DW-1:0] reg_rdata_o,
  output logic              ser_clk_o,
  output logic              ser_out_o,
  input  logic              ser_in_i,
  output logic              irq_o
);

  // Named internal events, visible to the bound checker
  logic [SSR_MODE_W-1:0] mode_w;
  logic [SSR_DW-1:0]     shreg_w, load_w;
  logic irq_en_w, data_acc_w, data_wr_w;
  logic flag_w, active_w, en_w;
  logic tick_w, fall_w, rise_w, done_w;

  assign en_w = mode_runs(mode_w);

  ssr_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (reg_addr_i),
    .wr_i       (reg_wr_i),
    .rd_i       (reg_rd_i),
    .wdata_i    (reg_wdata_i),
    .shreg_i    (shreg_w),
    .flag_i     (flag_w),
    .rdata_o    (reg_rdata_o),
    .mode_o     (mode_w),
    .irq_en_o   (irq_en_w),
    .data_acc_o (data_acc_w),
    .data_wr_o  (data_wr_w),
    .load_o     (load_w)
  );

  ssr_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active_w),
    .en_i      (en_w),
    .restart_i (data_acc_w),
    .tick_o    (tick_w),
    .fall_o    (fall_w),
    .rise_o    (rise_w),
    .sclk_o    (ser_clk_o)
  );

  ssr_shifter u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_w),
    .data_acc_i  (data_acc_w),
    .data_wr_i   (data_wr_w),
    .load_i      (load_w),
    .fall_i      (fall_w),
    .rise_i      (rise_w),
    .ser_in_i    (ser_in_i),
    .shreg_o     (shreg_w),
    .ser_out_o   (ser_out_o),
    .active_o    (active_w),
    .flag_o      (flag_w),
    .byte_done_o (done_w)
  );

  assign irq_o = flag_w & irq_en_w;

endmodule

// File: rtl/ssr_top_chk.sv
module ssr_top_chk
  import ssr_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [SSR_MODE_W-1:0] mode,
  input logic                  en,
  input logic                  data_acc,
  input logic                  tick,
  input logic                  byte_done,
  input logic                  active,
  input logic                  flag,
  input logic                  sclk,
  input logic                  sout,
  input logic                  irq
);

  // R10: a data access clears the flag on the next edge
  assert_clear_on_access_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_acc |=> !flag);

  // R8: the eighth rising edge sets the flag
  assert_set_on_eighth_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done |=> flag);

  // R8: the flag never rises without a completed byte
  assert_flag_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag) |-> $past(byte_done));

  // R8: shift-out stops after one byte
  assert_out_stops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && mode == SSR_OUT_INT) |=> !active);

  // R3: a disabled mode parks the serial clock high
  assert_idle_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> sclk);

  // R3: a disabled mode leaves the data output alone
  assert_hold_out_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> $stable(sout));

  // R5: each divider tick flips the serial clock
  assert_toggle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> (sclk != $past(sclk)));

  // R11: the interrupt needs a pending flag
  assert_irq_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq |-> flag);

endmodule

bind ssr_top ssr_top_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode      (mode_w),
  .en        (en_w),
  .data_acc  (data_acc_w),
  .tick      (tick_w),
  .byte_done (done_w),
  .active    (active_w),
  .flag      (flag_w),
  .sclk      (ser_clk_o),
  .sout      (ser_out_o),
  .irq       (irq_o)
);

// File: tb/ssr_top_test.sv
`timescale 1ns/1ps
module ssr_top_test;

  localparam int DIV = 2;
  localparam int BC  = 16 * DIV;   // cycles from access to completion

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sclk, sout, irq;
  logic       sin = 1'b0;

  int tests = 0, fails = 0;
  int mon_tests = 0, mon_fails = 0;
  bit done = 0;

  // Scoreboard and stimulus state
  logic [7:0]  sb_q[$];
  bit          mon_on = 0, in_on = 0;
  int          epoch = 0;
  logic [15:0] in_stream = '0;

  always #4 clk = ~clk;   // 125 MHz

  ssr_top #(.ADDR_W(2), .DIV_HALF(DIV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_rd_i(rd), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ser_clk_o(sclk), .ser_out_o(sout), .ser_in_i(sin), .irq_o(irq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask

  // Driver: queue the expected serial byte, then start it
  task automatic send_byte(input logic [7:0] b);
    sb_q.push_back(b);
    epoch++;
    reg_write(2'd0, b);
  endtask

  // Counts low serial-clock samples over n cycles
  task automatic count_lows(input int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sclk == 1'b0) lows++;
    end
  endtask

  // Monitor: captures shift-out bytes on rising serial edges and drives shift-in bits on falling ones
  initial begin
    logic prev = 1'b1;
    logic [7:0] cap = '0;
    int ncap = 0, seen = 0, idx = 0;
    forever begin
      @(negedge clk);
      if (epoch != seen) begin seen = epoch; ncap = 0; idx = 0; end
      if (mon_on && !prev && sclk) begin
        cap = {cap[6:0], sout};
        ncap++;
        if (ncap == 8) begin
          logic [7:0] exp;
          ncap = 0;
          mon_tests++;
          if (sb_q.size() == 0) begin
            mon_fails++;
            $display("FAIL R6 unexpected byte actual=%0h expected=none", cap);
          end else begin
            exp = sb_q.pop_front();
            if (cap !== exp) begin
              mon_fails++;
              $display("FAIL R6 shift-out byte actual=%0h expected=%0h", cap, exp);
            end
          end
        end
      end
      if (in_on && prev && !sclk) begin
        sin = (idx < 16) ? in_stream[15-idx] : 1'b0;
        idx++;
      end
      prev = sclk;
    end
  end

  // Watchdog
  initial begin
    #(8 * 150000);
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests + mon_tests + 1, fails + mon_fails + 1);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int lows;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    peek(2'd0, d); chk("R1 data", d, 8'h00);
    peek(2'd1, d); chk("R1 ctrl", d, 8'h00);
    peek(2'd2, d); chk("R1 flags", d, 8'h00);
    chk("R1 sclk/sout/irq", {5'b0, sclk, sout, irq}, 8'b0000_0100);

    // R2: field placement
    reg_write(2'd1, 8'hFF); peek(2'd1, d); chk("R2 ctrl mode bits", d, 8'h1C);
    reg_write(2'd3, 8'hFF); peek(2'd3, d); chk("R2 ien bit", d, 8'h04);
    reg_write(2'd3, 8'h00);

    // R3: unused code 111 (set above) and code 000 stay idle
    reg_write(2'd0, 8'h77);
    count_lows(3 * BC, lows); chk("R3 code 111 sclk lows", 8'(lows), 8'd0);
    peek(2'd2, d); chk("R3 code 111 flag", d, 8'h00);
    reg_write(2'd1, 8'h00);
    reg_write(2'd0, 8'h3E);
    count_lows(3 * BC, lows); chk("R3 code 000 sclk lows", 8'(lows), 8'd0);
    peek(2'd0, d); chk("R3 load while off", d, 8'h3E);

    // R6/R8: shift-out byte, flag on the exact cycle
    reg_write(2'd1, 8'h14);
    mon_on = 1;
    send_byte(8'hA5);
    repeat (BC - 1) @(negedge clk);
    peek(2'd2, d); chk("R8 flag one cycle early", d, 8'h00);
    @(negedge clk);
    peek(2'd2, d); chk("R8 flag on eighth edge", d, 8'h04);
    count_lows(8, lows); chk("R8 shift-out parks sclk", 8'(lows), 8'd0);

    // R11: interrupt gating
    chk("R11 irq masked", {7'b0, irq}, 8'h00);
    reg_write(2'd3, 8'h04);
    chk("R11 irq enabled", {7'b0, irq}, 8'h01);

    // R10: read of data clears flag; R4: it also restarts (zero-filled byte)
    sb_q.push_back(8'h00);
    reg_read(2'd0, d);
    peek(2'd2, d); chk("R10 flag cleared by read", d, 8'h00);
    chk("R10 irq dropped", {7'b0, irq}, 8'h00);
    repeat (BC + 2) @(negedge clk);
    reg_write(2'd3, 8'h00);
    send_byte(8'h3C);
    repeat (BC + 2) @(negedge clk);

    // R4: restart mid-byte pushes completion back
    mon_on = 0;
    reg_write(2'd0, 8'hFF);
    repeat (10) @(negedge clk);
    reg_write(2'd0, 8'h81);
    repeat (BC - 1) @(negedge clk);
    peek(2'd2, d); chk("R4 no flag from old count", d, 8'h00);
    @(negedge clk);
    peek(2'd2, d); chk("R4 flag after restart", d, 8'h04);

    // R12: halt mid-sequence
    reg_write(2'd0, 8'h55);
    repeat (10) @(negedge clk);
    reg_write(2'd1, 8'h00);
    count_lows(BC + 4, lows); chk("R12 halted sclk lows", 8'(lows), 8'd0);
    peek(2'd2, d); chk("R12 no flag", d, 8'h00);

    // R7/R9: continuous shift-in, two bytes without a read
    reg_write(2'd1, 8'h04);
    in_stream = 16'hC65A;
    epoch++;
    in_on = 1;
    reg_write(2'd0, 8'h00);
    for (int i = 0; i < 4 * BC; i++) begin
      peek(2'd2, d);
      if (d[2]) break;
      @(negedge clk);
    end
    peek(2'd0, d); chk("R7 first byte MSB first", d, 8'hC6);
    repeat (BC) @(negedge clk);
    peek(2'd0, d); chk("R9 unread byte overwritten", d, 8'h5A);
    reg_read(2'd0, d);
    peek(2'd2, d); chk("R10 flag cleared in shift-in", d, 8'h00);
    in_on = 0;
    reg_write(2'd1, 8'h00);

    chk("R6 scoreboard drained", 8'(sb_q.size()), 8'd0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests + mon_tests, fails + mon_fails);
    $finish;
  end

endmodule